// File: doc/BRIEF.md
# Multi-line serial register interface

This block is the bus-facing register bank for a group of asynchronous serial lines. Each line owns four 16-bit registers in an eight-byte window: receive status, receive data, transmit status and transmit data. A bus access is steered to one line and one register by its address. Reads return register contents on the same cycle. Reading the receive data register also consumes the character and clears its flags.

The line-side logic delivers received characters as one-cycle strobes, with a break qualifier, and reports the end of each transmitted character with a completion strobe. The block keeps the done and interrupt-enable state of each direction. It folds overrun and break conditions into the upper bits of the receive data word and raises separate receive and transmit interrupt requests for every line. A write to a transmit data register produces a one-cycle start pulse, together with the held character, for the serializer. A per-line reset input returns one line to its idle state.

Top module: `serial_regbank`

## Requirements
- R1: The line index is ((bus_addr - BASE_ADDR) >> 3) taken modulo 2^$clog2(NUM_LINES). Offset bits 2:1 select the register: 0 is receive status, 1 is receive data, 2 is transmit status and 3 is transmit data. Addresses that differ only above the line field reach the same line.
- R2: A read of receive data returns {error bit 15, overrun bit 14, break bit 13, zeros in bits 12:8, character in 7:0}. On the following edge it clears receive-done and withdraws that line's receive request.
- R3: When a character arrives and receive-done is clear, receive-done is set and the stored word holds the character with bits 15:13 zero. When receive-done is still set, the stored word holds the new character with bits 15 and 14 set. In either case the receive request is raised if receive interrupt-enable is set. A request is never pending without both done and enable.
- R4: A character strobe that carries the break qualifier stores 16'hA000 (error and break set, character zero), under the same done and overrun rules as R3.
- R5: Receive status reads done in bit 7 and interrupt-enable in bit 6, with all other bits zero. A write changes only bit 6.
- R6: A byte write (bus_byte=1) to an odd address of either status register changes nothing.
- R7: A status write that clears interrupt-enable withdraws that direction's request. A status write that sets it while done is set raises the request on the next cycle.
- R8: Every write to transmit data clears transmit-done, withdraws the transmit request, and drives tx_start for one cycle on the cycle after the write. The character is loaded from bus_wdata[7:0] only when the address is even, and tx_data presents the held character.
- R9: Transmit status reads done in bit 7, interrupt-enable in bit 6, maintenance in bit 2 and transmit-break in bit 0, with other bits zero. Only bits 6, 2 and 0 are writable.
- R10: A transmit completion strobe sets transmit-done and raises the transmit request if transmit interrupt-enable is set.
- R11: Writes to receive data have no effect. Transmit data reads the held character in bits 7:0 with zeros above.
- R12: After chip reset, or one cycle after line_rst, the affected line reads receive status 0, receive data 0, transmit status 16'h0080 and transmit data 0, with both of its requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_byte | input | 1 | Write is a single byte at bus_addr |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rx_stb | input | NUM_LINES | Character received, one bit per line |
| rx_chr | input | 8*NUM_LINES | Received character, line i in bits 8i+7:8i |
| rx_brk | input | NUM_LINES | Qualifies rx_stb as a break |
| tx_done_stb | input | NUM_LINES | Transmitter finished the current character |
| line_rst | input | NUM_LINES | Synchronous reset of one line |
| tx_start | output | NUM_LINES | One-cycle start pulse per line |
| tx_data | output | 8*NUM_LINES | Held transmit character per line |
| rx_irq | output | NUM_LINES | Receive interrupt request per line |
| tx_irq | output | NUM_LINES | Transmit interrupt request per line |

## Verification
The properties assume that bus_rd and bus_wr are never high together, and that each asserts for one cycle per access. They also take a line reset to dominate every other event on that line in the same cycle. The read-clear and odd-byte properties are qualified so that they do not fire when a character strobe or line reset hits the same line on the same cycle. The bench applies one bus access or one line-side strobe per cycle, never overlapping. It drives all inputs at the falling edge, so every property's precondition occurs in isolation.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

    typedef enum logic [1:0] {
        SEL_RXCSR = 2'd0,
        SEL_RXBUF = 2'd1,
        SEL_TXCSR = 2'd2,
        SEL_TXBUF = 2'd3
    } regsel_e;

    localparam int DONE_BIT  = 7;
    localparam int IE_BIT    = 6;
    localparam int MAINT_BIT = 2;
    localparam int TBRK_BIT  = 0;
    localparam int ERR_BIT   = 15;
    localparam int OVR_BIT   = 14;
    localparam int BRK_BIT   = 13;

    typedef struct packed {
        logic       done;
        logic       ie;
        logic       err;
        logic       ovr;
        logic       brk;
        logic [7:0] chr;
        logic       irq;
    } rx_state_t;

    typedef struct packed {
        logic       done;
        logic       ie;
        logic       maint;
        logic       tbrk;
        logic [7:0] chr;
        logic       irq;
        logic       start;
    } tx_state_t;

endpackage

// File: rtl/serial_regbank_decode.sv
module serial_regbank_decode
    import serial_regbank_pkg::*;
#(
    parameter int                NUM_LINES = 16,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0100
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LINES-1:0] line_sel,
    output regsel_e              regsel,
    output logic                 odd
);
    localparam int LW = $clog2(NUM_LINES);

    logic [ADDR_W-1:0] offset;
    logic [LW-1:0]     line_idx;

    always_comb begin
        offset   = addr - BASE_ADDR;
        line_idx = offset[3 +: LW];
        regsel   = regsel_e'(offset[2:1]);
        odd      = offset[0];
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
        assign line_sel[i] = (line_idx == LW'(i));
    end

endmodule

// File: rtl/serial_regbank_rx_line.sv
module serial_regbank_rx_line
    import serial_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_rst,
    input  logic        rd_buf,
    input  logic        wr_csr,
    input  logic        wr_ie,
    input  logic        chr_stb,
    input  logic [7:0]  chr_in,
    input  logic        brk_in,
    output logic [15:0] csr_word,
    output logic [15:0] buf_word,
    output logic        irq,
    output logic        done,
    output logic        ie
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_csr) begin
            st_d.ie = wr_ie;
            if (!wr_ie)
                st_d.irq = 1'b0;
            else if (st_q.done)
                st_d.irq = 1'b1;
        end
        if (rd_buf) begin
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (chr_stb) begin
            st_d.ovr  = st_d.done;
            st_d.err  = st_d.done | brk_in;
            st_d.brk  = brk_in;
            st_d.chr  = brk_in ? 8'h00 : chr_in;
            st_d.done = 1'b1;
            if (st_d.ie)
                st_d.irq = 1'b1;
        end
        if (line_rst)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        csr_word           = '0;
        csr_word[DONE_BIT] = st_q.done;
        csr_word[IE_BIT]   = st_q.ie;
        buf_word           = '0;
        buf_word[ERR_BIT]  = st_q.err;
        buf_word[OVR_BIT]  = st_q.ovr;
        buf_word[BRK_BIT]  = st_q.brk;
        buf_word[7:0]      = st_q.chr;
    end

    assign irq  = st_q.irq;
    assign done = st_q.done;
    assign ie   = st_q.ie;

endmodule

// File: rtl/serial_regbank_tx_line.sv
module serial_regbank_tx_line
    import serial_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_rst,
    input  logic        wr_csr,
    input  logic        wr_buf,
    input  logic        load_chr,
    input  logic        wr_ie,
    input  logic        wr_maint,
    input  logic        wr_tbrk,
    input  logic [7:0]  wr_chr,
    input  logic        done_stb,
    output logic [15:0] csr_word,
    output logic [15:0] buf_word,
    output logic        irq,
    output logic        start,
    output logic [7:0]  chr_out,
    output logic        done
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        // completion is applied first so that a write in the same cycle wins
        if (done_stb) begin
            st_d.done = 1'b1;
            if (st_d.ie)
                st_d.irq = 1'b1;
        end
        if (wr_csr) begin
            st_d.ie    = wr_ie;
            st_d.maint = wr_maint;
            st_d.tbrk  = wr_tbrk;
            if (!wr_ie)
                st_d.irq = 1'b0;
            else if (st_d.done)
                st_d.irq = 1'b1;
        end
        if (wr_buf) begin
            if (load_chr)
                st_d.chr = wr_chr;
            st_d.done  = 1'b0;
            st_d.irq   = 1'b0;
            st_d.start = 1'b1;
        end
        if (line_rst) begin
            st_d      = '0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_word            = '0;
        csr_word[DONE_BIT]  = st_q.done;
        csr_word[IE_BIT]    = st_q.ie;
        csr_word[MAINT_BIT] = st_q.maint;
        csr_word[TBRK_BIT]  = st_q.tbrk;
        buf_word            = {8'h00, st_q.chr};
    end

    assign irq     = st_q.irq;
    assign start   = st_q.start;
    assign chr_out = st_q.chr;
    assign done    = st_q.done;

endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
    import serial_regbank_pkg::*;
#(
    parameter int                NUM_LINES = 16,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic                   bus_byte,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]   rx_stb,
    input  logic [8*NUM_LINES-1:0] rx_chr,
    input  logic [NUM_LINES-1:0]   rx_brk,
    input  logic [NUM_LINES-1:0]   tx_done_stb,
    input  logic [NUM_LINES-1:0]   line_rst,
    output logic [NUM_LINES-1:0]   tx_start,
    output logic [8*NUM_LINES-1:0] tx_data,
    output logic [NUM_LINES-1:0]   rx_irq,
    output logic [NUM_LINES-1:0]   tx_irq
);
    logic [NUM_LINES-1:0] line_sel;
    regsel_e              regsel;
    logic                 odd;
    logic                 odd_byte;

    logic [NUM_LINES-1:0] rx_done_vec, rx_ie_vec, tx_done_vec;
    logic [15:0]          rx_csr_w [NUM_LINES];
    logic [15:0]          rx_buf_w [NUM_LINES];
    logic [15:0]          tx_csr_w [NUM_LINES];
    logic [15:0]          tx_buf_w [NUM_LINES];

    serial_regbank_decode #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) decode_i (
        .addr     (bus_addr),
        .line_sel (line_sel),
        .regsel   (regsel),
        .odd      (odd)
    );

    assign odd_byte = bus_byte & odd;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic hit;
        assign hit = line_sel[i];

        serial_regbank_rx_line rx_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_rst (line_rst[i]),
            .rd_buf   (bus_rd & hit & (regsel == SEL_RXBUF)),
            .wr_csr   (bus_wr & hit & (regsel == SEL_RXCSR) & ~odd_byte),
            .wr_ie    (bus_wdata[IE_BIT]),
            .chr_stb  (rx_stb[i]),
            .chr_in   (rx_chr[8*i +: 8]),
            .brk_in   (rx_brk[i]),
            .csr_word (rx_csr_w[i]),
            .buf_word (rx_buf_w[i]),
            .irq      (rx_irq[i]),
            .done     (rx_done_vec[i]),
            .ie       (rx_ie_vec[i])
        );

        serial_regbank_tx_line tx_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_rst (line_rst[i]),
            .wr_csr   (bus_wr & hit & (regsel == SEL_TXCSR) & ~odd_byte),
            .wr_buf   (bus_wr & hit & (regsel == SEL_TXBUF)),
            .load_chr (~odd),
            .wr_ie    (bus_wdata[IE_BIT]),
            .wr_maint (bus_wdata[MAINT_BIT]),
            .wr_tbrk  (bus_wdata[TBRK_BIT]),
            .wr_chr   (bus_wdata[7:0]),
            .done_stb (tx_done_stb[i]),
            .csr_word (tx_csr_w[i]),
            .buf_word (tx_buf_w[i]),
            .irq      (tx_irq[i]),
            .start    (tx_start[i]),
            .chr_out  (tx_data[8*i +: 8]),
            .done     (tx_done_vec[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (line_sel[i]) begin
                unique case (regsel)
                    SEL_RXCSR: bus_rdata = rx_csr_w[i];
                    SEL_RXBUF: bus_rdata = rx_buf_w[i];
                    SEL_TXCSR: bus_rdata = tx_csr_w[i];
                    SEL_TXBUF: bus_rdata = tx_buf_w[i];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk #(
    parameter int                NUM_LINES = 16,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0100
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic                 bus_byte,
    input logic [NUM_LINES-1:0] rx_stb,
    input logic [NUM_LINES-1:0] tx_done_stb,
    input logic [NUM_LINES-1:0] line_rst,
    input logic [NUM_LINES-1:0] tx_start,
    input logic [NUM_LINES-1:0] rx_irq,
    input logic [NUM_LINES-1:0] tx_irq,
    input logic [NUM_LINES-1:0] rx_done_vec,
    input logic [NUM_LINES-1:0] rx_ie_vec,
    input logic [NUM_LINES-1:0] tx_done_vec
);
    localparam int LW = $clog2(NUM_LINES);

    logic [ADDR_W-1:0] off;
    logic [LW-1:0]     lnum;
    logic [1:0]        rsel;
    assign off  = bus_addr - BASE_ADDR;
    assign lnum = off[3 +: LW];
    assign rsel = off[2:1];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        logic here;
        assign here = (lnum == LW'(i));

        p_rx_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rx_irq[i] |-> (rx_done_vec[i] && rx_ie_vec[i]));

        p_buf_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && here && rsel == 2'd1 && !rx_stb[i] && !line_rst[i])
            |=> (!rx_done_vec[i] && !rx_irq[i]));

        p_odd_status_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_byte && off[0] && here && rsel == 2'd0 && !line_rst[i])
            |=> $stable(rx_ie_vec[i]));

        p_tx_start_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && here && rsel == 2'd3 && !line_rst[i])
            |=> (tx_start[i] && !tx_done_vec[i] && !tx_irq[i]));

        p_tx_complete_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_done_stb[i] && !line_rst[i] && !(bus_wr && here && rsel == 2'd3))
            |=> tx_done_vec[i]);

        p_line_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
            line_rst[i] |=> (tx_done_vec[i] && !rx_done_vec[i] && !rx_irq[i] && !tx_irq[i]));
    end

endmodule

bind serial_regbank serial_regbank_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_byte    (bus_byte),
    .rx_stb      (rx_stb),
    .tx_done_stb (tx_done_stb),
    .line_rst    (line_rst),
    .tx_start    (tx_start),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq),
    .rx_done_vec (rx_done_vec),
    .rx_ie_vec   (rx_ie_vec),
    .tx_done_vec (tx_done_vec)
);

// File: tb/serial_regbank_tb_top.sv
module serial_regbank_tb_top;
    localparam int          N    = 16;
    localparam int          AW   = 16;
    localparam logic [15:0] BASE = 16'h0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [N-1:0]  rx_stb = '0, rx_brk = '0, tx_done_stb = '0, line_rst = '0;
    logic [8*N-1:0] rx_chr = '0;
    logic [N-1:0]  tx_start, rx_irq, tx_irq;
    logic [8*N-1:0] tx_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [15:0] rd_val;

    always #5 clk = ~clk;

    serial_regbank #(.NUM_LINES(N), .ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_stb(rx_stb), .rx_chr(rx_chr),
        .rx_brk(rx_brk), .tx_done_stb(tx_done_stb), .line_rst(line_rst),
        .tx_start(tx_start), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    function automatic logic [15:0] ra(int ln, int rg);
        return BASE + 16'(ln * 8) + 16'(rg * 2);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [15:0] a);
        bus_addr = a; bus_rd = 1'b1;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d, logic b);
        bus_addr = a; bus_wdata = d; bus_byte = b; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rx_send(int ln, logic [7:0] c, logic b);
        rx_stb[ln] = 1'b1; rx_brk[ln] = b; rx_chr[8*ln +: 8] = c;
        @(negedge clk);
        rx_stb[ln] = 1'b0; rx_brk[ln] = 1'b0;
    endtask

    task automatic tx_fin(int ln);
        tx_done_stb[ln] = 1'b1;
        @(negedge clk);
        tx_done_stb[ln] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 chip reset state
        for (int l = 0; l < N; l++) begin
            rd(ra(l, 0)); chk("R12 rxcsr", rd_val, 16'h0000);
            rd(ra(l, 2)); chk("R12 txcsr", rd_val, 16'h0080);
            rd(ra(l, 3)); chk("R12 txbuf", rd_val, 16'h0000);
        end
        chk("R12 irqs", {rx_irq, tx_irq}, 32'h0);

        for (int l = 0; l < N; l++) begin
            logic [7:0] c, c2, d;
            c  = 8'((l * 29 + 7) & 255);
            c2 = c ^ 8'h5A;
            d  = 8'((l * 53 + 3) & 255);

            rx_send(l, c, 1'b0);
            rd(ra(l, 0)); chk("R5 rxcsr done", rd_val, 16'h0080);
            chk("R3 no irq without ie", 16'(rx_irq[l]), 16'h0);
            rd(ra(l + N, 0)); chk("R1 alias line", rd_val, 16'h0080);
            rd(ra((l + 1) % N, 0)); chk("R1 neighbour untouched", rd_val, 16'h0000);
            rd(ra(l, 1)); chk("R2 rxbuf char", rd_val, {8'h00, c});
            rd(ra(l, 0)); chk("R2 read clears done", rd_val, 16'h0000);

            wr(ra(l, 1), 16'hFFFF, 1'b0);
            rd(ra(l, 0)); chk("R11 rxbuf write no done", rd_val, 16'h0000);
            rd(ra(l, 1)); chk("R11 rxbuf write no data", rd_val, {8'h00, c});

            rx_send(l, c, 1'b0);
            rx_send(l, c2, 1'b0);
            rd(ra(l, 1)); chk("R3 overrun word", rd_val, {8'hC0, c2});

            rx_send(l, c, 1'b1);
            rd(ra(l, 1)); chk("R4 break word", rd_val, 16'hA000);

            rx_send(l, c, 1'b0);
            wr(ra(l, 0), 16'h0040, 1'b0);
            chk("R7 ie set while done", 16'(rx_irq[l]), 16'h1);
            rd(ra(l, 0)); chk("R5 rxcsr done+ie", rd_val, 16'h00C0);
            wr(ra(l, 0), 16'hFFBF, 1'b0);
            chk("R7 ie clear withdraws", 16'(rx_irq[l]), 16'h0);
            rd(ra(l, 0)); chk("R5 only ie writable", rd_val, 16'h0080);
            wr(ra(l, 0), 16'h0040, 1'b0);
            rd(ra(l, 1));
            chk("R2 read withdraws irq", 16'(rx_irq[l]), 16'h0);
            rx_send(l, c2, 1'b0);
            chk("R3 arrival raises irq", 16'(rx_irq[l]), 16'h1);
            rd(ra(l, 1));
            wr(ra(l, 0) + 16'd1, 16'h0000, 1'b1);
            rd(ra(l, 0)); chk("R6 odd rx status ignored", rd_val, 16'h0040);
            wr(ra(l, 0), 16'h0000, 1'b0);

            wr(ra(l, 3), {8'h12, d}, 1'b0);
            chk("R8 start pulse", 16'(tx_start[l]), 16'h1);
            chk("R8 tx data", 16'(tx_data[8*l +: 8]), 16'(d));
            rd(ra(l, 2)); chk("R8 done cleared", rd_val, 16'h0000);
            chk("R8 start one cycle", 16'(tx_start[l]), 16'h0);
            rd(ra(l, 3)); chk("R11 txbuf read", rd_val, {8'h00, d});

            tx_fin(l);
            rd(ra(l, 2)); chk("R10 done set", rd_val, 16'h0080);
            chk("R10 no irq without ie", 16'(tx_irq[l]), 16'h0);
            wr(ra(l, 2), 16'hFFFF, 1'b0);
            chk("R7 tx ie set while done", 16'(tx_irq[l]), 16'h1);
            rd(ra(l, 2)); chk("R9 txcsr writable bits", rd_val, 16'h00C5);
            wr(ra(l, 2) + 16'd1, 16'h0000, 1'b1);
            rd(ra(l, 2)); chk("R6 odd tx status ignored", rd_val, 16'h00C5);
            wr(ra(l, 3) + 16'd1, 16'h00FF, 1'b1);
            chk("R8 odd write withdraws irq", 16'(tx_irq[l]), 16'h0);
            chk("R8 odd write starts", 16'(tx_start[l]), 16'h1);
            rd(ra(l, 3)); chk("R8 odd write keeps char", rd_val, {8'h00, d});
            tx_fin(l);
            chk("R10 completion raises irq", 16'(tx_irq[l]), 16'h1);

            rx_send(l, c, 1'b0);
            line_rst[l] = 1'b1;
            @(negedge clk);
            line_rst[l] = 1'b0;
            chk("R12 line reset irqs", {15'h0, rx_irq[l] | tx_irq[l]}, 16'h0);
            rd(ra(l, 0)); chk("R12 line reset rxcsr", rd_val, 16'h0000);
            rd(ra(l, 1)); chk("R12 line reset rxbuf", rd_val, 16'h0000);
            rd(ra(l, 2)); chk("R12 line reset txcsr", rd_val, 16'h0080);
            rd(ra(l, 3)); chk("R12 line reset txbuf", rd_val, 16'h0000);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule